// File: doc/BRIEF.md
# Selective Set-Associative Victim Bank

An extra storage bank that sits beside a group of distributed cache banks and catches the lines they evict, so that a line pushed out of a busy bank can stay on chip a while longer. A filter runs on every eviction. A line is kept only when its origin flag marks it as coming from a bank near a requesting core. Lines from any other bank, such as a central bank, go straight to the memory writeback path. The bank is set-associative: the low address bits pick the set, and the remaining bits form the tag.

When a request misses in the main banks, it probes the bank through the lookup port. On a hit, the bank returns the line with its dirty flag and invalidates its own copy, so the line can be put back into the main array and is never held in both places. Each set replaces its ways in least-recently-inserted order. When a displaced entry is dirty, it leaves through a valid/ready writeback port. A clean displaced entry is dropped.

A lookup always takes priority over an eviction. `busy_o` holds off the eviction source while a lookup is present, and also while a writeback is waiting to be accepted.

Top module: `victim_bank`

## Requirements
- R1: After reset, no entry is valid: `busy_o`, `wb_valid_o` and `resp_valid_o` are low, and any lookup misses.
- R2: An eviction with `evict_near_i`=1 is stored. A later lookup of the same address returns `resp_valid_o`=1 and `resp_hit_o`=1 with the stored data and dirty flag in the cycle after the lookup is presented. A cycle without a lookup gives `resp_valid_o`=0.
- R3: A lookup hit removes the entry, so a second lookup of the same address misses.
- R4: An eviction with `evict_near_i`=0 is not stored. It appears on the writeback port with its own address and data. `wb_valid_o` only rises after an eviction has been accepted.
- R5: The set is `addr[log2(SETS)-1:0]` and the tag is the remaining upper bits. Lines with equal tags in different sets coexist, and up to WAYS lines of one set are all held.
- R6: An insertion into a full set displaces the way inserted (or rewritten) least recently. If that entry is dirty, it is sent to the writeback port as {tag, set} with its data.
- R7: A clean displaced entry is dropped, and no writeback occurs.
- R8: While `lookup_valid_i` is high, `busy_o` is high and no eviction is accepted. A held eviction is then accepted in the first cycle without a lookup.
- R9: While `wb_valid_o`=1 and `wb_ready_i`=0, the writeback address and data stay stable and `busy_o` is high, so evictions stall.
- R10: Evicting an address that is already resident overwrites that entry in place, ORs the dirty flags together, and displaces nothing.
- R11: A way freed by a lookup hit is filled before any valid entry is displaced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evict_valid_i | input | 1 | Eviction offered; taken when `busy_o` is low |
| evict_addr_i | input | ADDR_W | Line address of the evicted line |
| evict_data_i | input | DATA_W | Evicted line data |
| evict_dirty_i | input | 1 | Evicted line is modified |
| evict_near_i | input | 1 | 1: line came from a bank near a core; 0: any other bank |
| busy_o | output | 1 | Eviction back-pressure |
| lookup_valid_i | input | 1 | Lookup request from a main-bank miss |
| lookup_addr_i | input | ADDR_W | Lookup line address |
| resp_valid_o | output | 1 | Lookup result valid, one cycle after the request |
| resp_hit_o | output | 1 | Lookup found the line |
| resp_data_o | output | DATA_W | Returned line data |
| resp_dirty_o | output | 1 | Returned line dirty flag |
| wb_valid_o | output | 1 | Writeback toward memory valid |
| wb_ready_i | input | 1 | Memory accepts the writeback |
| wb_addr_o | output | ADDR_W | Writeback line address |
| wb_data_o | output | DATA_W | Writeback line data |

## Verification
The bench builds the bank with ADDR_W=12 and DATA_W=32, and keeps the default 4 ways and 16 sets. With these values each address is three hex digits whose last digit is the set. This makes it easy to fill a single set to capacity and force an LRU displacement, to place equal tags in neighbouring sets, and to tell the {tag, set} writeback address of a displaced entry apart from the address of the incoming line. A narrow data path is enough, because only data identity matters.

// File: rtl/vb_pkg.sv
package vb_pkg;
  typedef enum logic {
    SRC_FAR  = 1'b0,
    SRC_NEAR = 1'b1
  } src_kind_e;
endpackage

// File: rtl/vb_way_match.sv
module vb_way_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 8,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]            valid_i,
  input  logic [WAYS-1:0][TAG_W-1:0] tags_i,
  input  logic [TAG_W-1:0]           tag_i,
  output logic                       hit_o,
  output logic [WAY_W-1:0]           way_o
);
  logic [WAYS-1:0] eq;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign eq[w] = valid_i[w] && (tags_i[w] == tag_i);
  end

  assign hit_o = |eq;

  always_comb begin
    way_o = '0;
    for (int w = 0; w < WAYS; w++)
      if (eq[w]) way_o = WAY_W'(w);
  end
endmodule

// File: rtl/vb_lru_pick.sv
module vb_lru_pick #(
  parameter int WAYS = 4,
  localparam int WAY_W = $clog2(WAYS),
  localparam int AGE_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]            valid_i,
  input  logic [WAYS-1:0][AGE_W-1:0] ages_i,
  output logic                       full_o,
  output logic [WAY_W-1:0]           way_o
);
  assign full_o = &valid_i;

  // lowest free way first; when full, the oldest way
  always_comb begin
    way_o = '0;
    if (full_o) begin
      for (int w = 0; w < WAYS; w++)
        if (ages_i[w] == AGE_W'(WAYS - 1)) way_o = WAY_W'(w);
    end else begin
      for (int w = WAYS - 1; w >= 0; w--)
        if (!valid_i[w]) way_o = WAY_W'(w);
    end
  end
endmodule

// File: rtl/vb_wb_slot.sv
module vb_wb_slot #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      valid_o <= 1'b0;
    else if (load_i)  valid_o <= 1'b1;
    else if (ready_i) valid_o <= 1'b0;
  end

  always_ff @(posedge clk_i) begin
    if (load_i) begin
      addr_o <= addr_i;
      data_o <= data_i;
    end
  end
endmodule

// File: rtl/victim_bank.sv
module victim_bank #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int WAYS   = 4,
  parameter int SETS   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evict_valid_i,
  input  logic [ADDR_W-1:0] evict_addr_i,
  input  logic [DATA_W-1:0] evict_data_i,
  input  logic              evict_dirty_i,
  input  logic              evict_near_i,
  output logic              busy_o,
  input  logic              lookup_valid_i,
  input  logic [ADDR_W-1:0] lookup_addr_i,
  output logic              resp_valid_o,
  output logic              resp_hit_o,
  output logic [DATA_W-1:0] resp_data_o,
  output logic              resp_dirty_o,
  output logic              wb_valid_o,
  input  logic              wb_ready_i,
  output logic [ADDR_W-1:0] wb_addr_o,
  output logic [DATA_W-1:0] wb_data_o
);
  import vb_pkg::*;

  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int WAY_W = $clog2(WAYS);
  localparam int AGE_W = $clog2(WAYS);

  // per-set state views
  logic [WAYS-1:0]             vld_all   [SETS];
  logic [WAYS-1:0]             dirty_all [SETS];
  logic [WAYS-1:0][AGE_W-1:0]  age_all   [SETS];
  logic [WAYS-1:0][TAG_W-1:0]  tag_all   [SETS];
  logic [WAYS-1:0][DATA_W-1:0] data_all  [SETS];

  logic [IDX_W-1:0] lk_idx, ev_idx;
  logic [TAG_W-1:0] lk_tag, ev_tag;
  assign lk_idx = lookup_addr_i[IDX_W-1:0];
  assign lk_tag = lookup_addr_i[ADDR_W-1:IDX_W];
  assign ev_idx = evict_addr_i[IDX_W-1:0];
  assign ev_tag = evict_addr_i[ADDR_W-1:IDX_W];

  // lookup side
  logic             lk_hit;
  logic [WAY_W-1:0] lk_way;
  logic             lk_inv;

  vb_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lk_match (
    .valid_i (vld_all[lk_idx]),
    .tags_i  (tag_all[lk_idx]),
    .tag_i   (lk_tag),
    .hit_o   (lk_hit),
    .way_o   (lk_way)
  );

  assign lk_inv = lookup_valid_i & lk_hit;

  // eviction side
  logic             ev_hit, set_full;
  logic [WAY_W-1:0] ev_hit_way, pick_way, ins_way;
  logic             wb_stall, ev_take, ev_keep, ev_pass;
  logic             displace, disp_dirty, new_dirty;

  vb_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_ev_match (
    .valid_i (vld_all[ev_idx]),
    .tags_i  (tag_all[ev_idx]),
    .tag_i   (ev_tag),
    .hit_o   (ev_hit),
    .way_o   (ev_hit_way)
  );

  vb_lru_pick #(.WAYS(WAYS)) u_pick (
    .valid_i (vld_all[ev_idx]),
    .ages_i  (age_all[ev_idx]),
    .full_o  (set_full),
    .way_o   (pick_way)
  );

  assign wb_stall   = wb_valid_o & ~wb_ready_i;
  assign busy_o     = lookup_valid_i | wb_stall;
  assign ev_take    = evict_valid_i & ~busy_o;
  assign ev_keep    = ev_take & (src_kind_e'(evict_near_i) == SRC_NEAR);
  assign ev_pass    = ev_take & (src_kind_e'(evict_near_i) == SRC_FAR);
  assign ins_way    = ev_hit ? ev_hit_way : pick_way;
  assign displace   = ~ev_hit & set_full;
  assign disp_dirty = displace & dirty_all[ev_idx][ins_way];
  assign new_dirty  = evict_dirty_i | (ev_hit & dirty_all[ev_idx][ins_way]);

  // storage, one block per set
  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic [WAYS-1:0]             vld_q, dirty_q;
    logic [WAYS-1:0][AGE_W-1:0]  age_q;
    logic [WAYS-1:0][TAG_W-1:0]  tag_q;
    logic [WAYS-1:0][DATA_W-1:0] data_q;
    logic ins_here, inv_here;

    assign ins_here = ev_keep & (ev_idx == IDX_W'(s));
    assign inv_here = lk_inv  & (lk_idx == IDX_W'(s));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q   <= '0;
        dirty_q <= '0;
        for (int w = 0; w < WAYS; w++) age_q[w] <= AGE_W'(w);
      end else begin
        if (inv_here) vld_q[lk_way] <= 1'b0;
        if (ins_here) begin
          vld_q[ins_way]   <= 1'b1;
          dirty_q[ins_way] <= new_dirty;
          for (int w = 0; w < WAYS; w++) begin
            if (WAY_W'(w) == ins_way)        age_q[w] <= '0;
            else if (age_q[w] < age_q[ins_way]) age_q[w] <= age_q[w] + 1'b1;
          end
        end
      end
    end

    always_ff @(posedge clk_i) begin
      if (ins_here) begin
        tag_q[ins_way]  <= ev_tag;
        data_q[ins_way] <= evict_data_i;
      end
    end

    assign vld_all[s]   = vld_q;
    assign dirty_all[s] = dirty_q;
    assign age_all[s]   = age_q;
    assign tag_all[s]   = tag_q;
    assign data_all[s]  = data_q;
  end

  // lookup response
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_valid_o <= 1'b0;
      resp_hit_o   <= 1'b0;
      resp_dirty_o <= 1'b0;
    end else begin
      resp_valid_o <= lookup_valid_i;
      resp_hit_o   <= lk_inv;
      resp_dirty_o <= lk_inv & dirty_all[lk_idx][lk_way];
    end
  end

  always_ff @(posedge clk_i) begin
    if (lk_inv) resp_data_o <= data_all[lk_idx][lk_way];
  end

  // writeback path
  logic              wb_load;
  logic [ADDR_W-1:0] wb_addr_d;
  logic [DATA_W-1:0] wb_data_d;

  assign wb_load   = ev_pass | (ev_keep & disp_dirty);
  assign wb_addr_d = ev_pass ? evict_addr_i : {tag_all[ev_idx][ins_way], ev_idx};
  assign wb_data_d = ev_pass ? evict_data_i : data_all[ev_idx][ins_way];

  vb_wb_slot #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (wb_load),
    .addr_i  (wb_addr_d),
    .data_i  (wb_data_d),
    .ready_i (wb_ready_i),
    .valid_o (wb_valid_o),
    .addr_o  (wb_addr_o),
    .data_o  (wb_data_o)
  );
endmodule

// File: rtl/vb_checker.sv
module vb_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              evict_valid_i,
  input logic              busy_o,
  input logic              lookup_valid_i,
  input logic              resp_valid_o,
  input logic              resp_hit_o,
  input logic              wb_valid_o,
  input logic              wb_ready_i,
  input logic [ADDR_W-1:0] wb_addr_o,
  input logic [DATA_W-1:0] wb_data_o
);
  assert_resp_follows_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lookup_valid_i |=> resp_valid_o);

  assert_resp_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lookup_valid_i |=> !resp_valid_o);

  assert_hit_in_resp_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_hit_o |-> resp_valid_o);

  assert_wb_after_evict_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wb_valid_o) |-> $past(evict_valid_i && !busy_o));

  assert_lookup_blocks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lookup_valid_i |-> busy_o);

  assert_wb_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_valid_o && !wb_ready_i) |=> (wb_valid_o && $stable(wb_addr_o) && $stable(wb_data_o)));

  assert_wb_stall_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_valid_o && !wb_ready_i) |-> busy_o);
endmodule

bind victim_bank vb_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_vb_checker (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .evict_valid_i  (evict_valid_i),
  .busy_o         (busy_o),
  .lookup_valid_i (lookup_valid_i),
  .resp_valid_o   (resp_valid_o),
  .resp_hit_o     (resp_hit_o),
  .wb_valid_o     (wb_valid_o),
  .wb_ready_i     (wb_ready_i),
  .wb_addr_o      (wb_addr_o),
  .wb_data_o      (wb_data_o)
);

// File: tb/tb_victim_bank.sv
module tb_victim_bank;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ev_valid = 1'b0, ev_dirty = 1'b0, ev_near = 1'b0;
  logic [AW-1:0] ev_addr = '0;
  logic [DW-1:0] ev_data = '0;
  logic          busy;
  logic          lk_valid = 1'b0;
  logic [AW-1:0] lk_addr = '0;
  logic          resp_valid, resp_hit, resp_dirty;
  logic [DW-1:0] resp_data;
  logic          wb_valid, wb_ready = 1'b1;
  logic [AW-1:0] wb_addr;
  logic [DW-1:0] wb_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  victim_bank #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .evict_valid_i(ev_valid), .evict_addr_i(ev_addr), .evict_data_i(ev_data),
    .evict_dirty_i(ev_dirty), .evict_near_i(ev_near), .busy_o(busy),
    .lookup_valid_i(lk_valid), .lookup_addr_i(lk_addr),
    .resp_valid_o(resp_valid), .resp_hit_o(resp_hit),
    .resp_data_o(resp_data), .resp_dirty_o(resp_dirty),
    .wb_valid_o(wb_valid), .wb_ready_i(wb_ready),
    .wb_addr_o(wb_addr), .wb_data_o(wb_data)
  );

  int n_vec = 0, n_bad = 0, wb_cnt = 0;
  logic [AW-1:0] wb_last_addr = '0;
  logic [DW-1:0] wb_last_data = '0;

  always @(negedge clk)
    if (rst_n && wb_valid && wb_ready) begin
      wb_cnt++;
      wb_last_addr = wb_addr;
      wb_last_data = wb_data;
    end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  task automatic evict(logic [AW-1:0] a, logic [DW-1:0] d, logic dirty, logic near);
    @(negedge clk);
    ev_valid = 1'b1; ev_addr = a; ev_data = d; ev_dirty = dirty; ev_near = near;
    while (busy) @(negedge clk);
    @(posedge clk); #1;
    ev_valid = 1'b0;
  endtask

  task automatic lookup(logic [AW-1:0] a, output logic hit, output logic [DW-1:0] d,
                        output logic dirty);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a;
    @(posedge clk); #1;
    hit = resp_hit; d = resp_data; dirty = resp_dirty;
    lk_valid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    logic h, dy; logic [DW-1:0] d;
    chk("R1 busy", busy, 0);
    chk("R1 wb_valid", wb_valid, 0);
    chk("R1 resp_valid", resp_valid, 0);
    lookup(12'h0E0, h, d, dy);
    chk("R1 lookup miss", h, 0);
  endtask

  task automatic t_insert_hit();
    logic h, dy; logic [DW-1:0] d; int c0;
    c0 = wb_cnt;
    evict(12'h123, 32'hA5A5_0123, 1'b1, 1'b1);
    idle(2);
    chk("R2 no writeback", wb_cnt - c0, 0);
    lookup(12'h123, h, d, dy);
    chk("R2 resp_valid", resp_valid, 1);
    chk("R2 hit", h, 1);
    chk("R2 data", d, 32'hA5A5_0123);
    chk("R2 dirty", dy, 1);
    idle(1);
    chk("R2 resp drops", resp_valid, 0);
    lookup(12'h123, h, d, dy);
    chk("R3 removed after hit", h, 0);
  endtask

  task automatic t_far();
    logic h, dy; logic [DW-1:0] d; int c0;
    c0 = wb_cnt;
    evict(12'h200, 32'hFA00_0200, 1'b0, 1'b0);
    idle(2);
    chk("R4 wb count", wb_cnt - c0, 1);
    chk("R4 wb addr", wb_last_addr, 12'h200);
    chk("R4 wb data", wb_last_data, 32'hFA00_0200);
    lookup(12'h200, h, d, dy);
    chk("R4 not stored", h, 0);
  endtask

  task automatic t_sets();
    logic h, dy; logic [DW-1:0] d;
    for (int i = 1; i <= 4; i++) evict(AW'((i << 4) | 2), DW'(32'h5E70_0000 + i), 1'b0, 1'b1);
    evict(12'h013, 32'h5E71_0013, 1'b0, 1'b1);
    for (int i = 1; i <= 4; i++) begin
      lookup(AW'((i << 4) | 2), h, d, dy);
      chk("R5 set full hit", h, 1);
      chk("R5 set full data", d, DW'(32'h5E70_0000 + i));
    end
    lookup(12'h013, h, d, dy);
    chk("R5 same tag other set", d, 32'h5E71_0013);
  endtask

  task automatic t_displace_dirty();
    logic h, dy; logic [DW-1:0] d; int c0;
    for (int i = 1; i <= 4; i++) evict(AW'((i << 8) | 5), DW'(32'hD000_0000 + i), 1'b1, 1'b1);
    idle(2);
    c0 = wb_cnt;
    evict(12'h505, 32'hD000_0005, 1'b1, 1'b1);
    idle(2);
    chk("R6 one writeback", wb_cnt - c0, 1);
    chk("R6 victim addr", wb_last_addr, 12'h105);
    chk("R6 victim data", wb_last_data, 32'hD000_0001);
    lookup(12'h105, h, d, dy);
    chk("R6 oldest gone", h, 0);
    lookup(12'h205, h, d, dy);
    chk("R6 next kept", h, 1);
    lookup(12'h505, h, d, dy);
    chk("R6 new present", d, 32'hD000_0005);
  endtask

  task automatic t_displace_clean();
    logic h, dy; logic [DW-1:0] d; int c0;
    c0 = wb_cnt;
    for (int i = 1; i <= 5; i++) evict(AW'((i << 8) | 6), DW'(32'hC000_0000 + i), 1'b0, 1'b1);
    idle(2);
    chk("R7 no writeback", wb_cnt - c0, 0);
    lookup(12'h106, h, d, dy);
    chk("R7 clean victim dropped", h, 0);
  endtask

  task automatic t_collide();
    logic h, dy; logic [DW-1:0] d;
    @(negedge clk);
    ev_valid = 1'b1; ev_addr = 12'h107; ev_data = 32'hC011_0107; ev_dirty = 1'b0; ev_near = 1'b1;
    lk_valid = 1'b1; lk_addr = 12'h0E7;
    #1;
    chk("R8 busy with lookup", busy, 1);
    @(posedge clk); #1;
    chk("R8 lookup served", resp_valid, 1);
    lk_valid = 1'b0;
    @(negedge clk);
    chk("R8 busy released", busy, 0);
    @(posedge clk); #1;
    ev_valid = 1'b0;
    lookup(12'h107, h, d, dy);
    chk("R8 held eviction stored", h, 1);
    chk("R8 held eviction data", d, 32'hC011_0107);
  endtask

  task automatic t_wb_stall();
    logic h, dy; logic [DW-1:0] d;
    wb_ready = 1'b0;
    evict(12'h30A, 32'h57A1_030A, 1'b0, 1'b0);
    chk("R9 wb pending", wb_valid, 1);
    @(negedge clk);
    ev_valid = 1'b1; ev_addr = 12'h40B; ev_data = 32'h57A1_040B; ev_dirty = 1'b0; ev_near = 1'b1;
    for (int i = 0; i < 3; i++) begin
      #1;
      chk("R9 busy while stalled", busy, 1);
      chk("R9 addr stable", wb_addr, 12'h30A);
      chk("R9 data stable", wb_data, 32'h57A1_030A);
      @(negedge clk);
    end
    #1;
    wb_ready = 1'b1;
    #1;
    chk("R9 busy drops on ready", busy, 0);
    @(posedge clk); #1;
    ev_valid = 1'b0;
    chk("R9 wb drained", wb_valid, 0);
    lookup(12'h40B, h, d, dy);
    chk("R9 stalled eviction stored", d, 32'h57A1_040B);
  endtask

  task automatic t_rewrite();
    logic h, dy; logic [DW-1:0] d; int c0;
    c0 = wb_cnt;
    evict(12'h10C, 32'h0000_AAAA, 1'b0, 1'b1);
    evict(12'h10C, 32'h0000_BBBB, 1'b1, 1'b1);
    for (int i = 2; i <= 4; i++) evict(AW'((i << 8) | 12), DW'(i), 1'b0, 1'b1);
    idle(2);
    chk("R10 nothing displaced", wb_cnt - c0, 0);
    lookup(12'h10C, h, d, dy);
    chk("R10 rewritten data", d, 32'h0000_BBBB);
    chk("R10 dirty merged", dy, 1);
    lookup(12'h40C, h, d, dy);
    chk("R10 fourth line kept", h, 1);
  endtask

  task automatic t_free_way();
    logic h, dy; logic [DW-1:0] d; int c0;
    for (int i = 1; i <= 4; i++) evict(AW'((i << 8) | 13), DW'(32'hF0E0_0000 + i), 1'b1, 1'b1);
    lookup(12'h20D, h, d, dy);
    chk("R11 removal hit", h, 1);
    idle(2);
    c0 = wb_cnt;
    evict(12'h50D, 32'hF0E0_0005, 1'b1, 1'b1);
    idle(2);
    chk("R11 freed way reused", wb_cnt - c0, 0);
    for (int i = 1; i <= 5; i++) begin
      if (i == 2) continue;
      lookup(AW'((i << 8) | 13), h, d, dy);
      chk("R11 resident", h, 1);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    report();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_insert_hit();
    t_far();
    t_sets();
    t_displace_dirty();
    t_displace_clean();
    t_collide();
    t_wb_stall();
    t_rewrite();
    t_free_way();
    idle(3);
    report();
  end
endmodule